// File: doc/BRIEF.md
# Program Status Register Controller

This block keeps the processor's program status: a 5-bit operating mode, three interrupt mask bits (fast interrupt F, normal interrupt I, asynchronous abort A), an endianness bit E and a 5-bit condition-flag group. The condition flags are written by the execute stage through a plain update pin. The other fields are changed only by commands that arrive on a valid/ready command port.

There are three commands. The first is a state-change command that carries a packed 10-bit immediate. It can clear or set any chosen subset of the mask bits and can load a new mode, but it has no effect while the register is in user mode. The second command writes the endianness bit. The third is a readback command, which places a masked 32-bit status word on a valid/ready output.

A configuration input can lock the fast-interrupt mask so that software cannot set it. The current mode and mask bits are always visible on dedicated output pins.

Command back-pressure works as follows. `cmd_ready` is low only while a readback word is held on the output and `rd_ready` is low. A command counts as taken when `cmd_valid` and `cmd_ready` are both high at a clock edge. A readback word stays valid, unchanged, until `rd_ready` is seen high at a clock edge. When `rd_ready` is high, a new readback can be taken in that same cycle.

Top module: `psr_ctrl`

## Requirements
- R1: After reset the mode is 5'b10011, F, I and A are 1, E is 0, the flags are 0 and `rd_valid` is 0.
- R2: A taken state-change command (`cmd_sel`=2'b00) outside user mode with immediate bit 9 set clears each mask bit that is selected. Immediate bit 5 selects F, bit 6 selects I and bit 7 selects A. The change is visible after the next clock edge.
- R3: The same command with bit 9 clear sets each selected mask bit. F is set only when `nmfi_lock` is low. With `nmfi_lock` high, F keeps its value.
- R4: A taken state-change command outside user mode with immediate bit 8 set loads the mode from immediate bits 4:0.
- R5: While the mode is user mode (5'b10000), a state-change command leaves the mode and all mask bits unchanged.
- R6: A taken endianness command (`cmd_sel`=2'b01) copies immediate bit 0 into E, in any mode.
- R7: A taken readback command (`cmd_sel`=2'b10) raises `rd_valid` after the next edge. The word is flags[4:0] at bits 31:27, E at bit 9, A at bit 8, I at bit 7, F at bit 6 and the mode at bits 4:0, under the mask 0xF8FF03DF. All other bits are 0.
- R8: While `rd_valid` is high and `rd_ready` is low, `rd_data` and `rd_valid` hold their values and `cmd_ready` is low. A command offered during that time is not taken and changes nothing.
- R9: `flag_we` loads `flag_in` into the flags at the next edge. A readback taken in the same cycle returns the flags from before the update.
- R10: Command select 2'b11 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_sel | input | 2 | 00 state change, 01 endianness, 10 readback, 11 none |
| cmd_imm | input | 10 | Command immediate |
| nmfi_lock | input | 1 | Blocks setting of F |
| flag_we | input | 1 | Condition-flag update strobe |
| flag_in | input | 5 | New condition flags |
| rd_valid | output | 1 | Readback word valid |
| rd_ready | input | 1 | Readback consumer ready |
| rd_data | output | 32 | Masked status word |
| mode_o | output | 5 | Current mode |
| f_o | output | 1 | Fast-interrupt mask |
| i_o | output | 1 | Interrupt mask |
| a_o | output | 1 | Abort mask |
| e_o | output | 1 | Endianness bit |

## Verification
A flag update from the execute stage can land in the same cycle as a readback command. The bench drives `flag_we` with new flags and takes a readback at the same edge. It expects that word to carry the old flags, and a second readback to show the new ones.

A second case is a command offered while a readback word is stalled. That command must be refused, and the bench judges this on `e_o` and on the held `rd_data`.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int MODE_W = 5;
  localparam int IMM_W  = 10;
  localparam int FLAG_W = 5;
  localparam int WORD_W = 32;

  localparam logic [MODE_W-1:0] MODE_USER = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_SVC  = 5'b10011;
  localparam logic [WORD_W-1:0] RD_MASK   = 32'hF8FF03DF;

  // immediate field positions of the state-change command
  localparam int IMM_F_SEL = 5;
  localparam int IMM_I_SEL = 6;
  localparam int IMM_A_SEL = 7;
  localparam int IMM_MODE  = 8;
  localparam int IMM_EN    = 9;

  // status word positions
  localparam int W_FLAG_LO = WORD_W - FLAG_W;
  localparam int W_E = 9;
  localparam int W_A = 8;
  localparam int W_I = 7;
  localparam int W_F = 6;

  typedef enum logic [1:0] {
    CMD_CHG  = 2'b00,
    CMD_END  = 2'b01,
    CMD_READ = 2'b10,
    CMD_NONE = 2'b11
  } psr_cmd_e;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic f;
    logic i;
    logic a;
    logic e;
  } psr_fields_t;

  localparam psr_fields_t PSR_RESET = '{mode: MODE_SVC, f: 1'b1, i: 1'b1, a: 1'b1, e: 1'b0};
endpackage

// File: rtl/psr_chg_unit.sv
module psr_chg_unit
  import psr_pkg::*;
(
  input  psr_fields_t        cur,
  input  logic [IMM_W-1:0]   imm,
  input  logic               nmfi_lock,
  output psr_fields_t        nxt
);
  localparam int NMASK = 3;

  logic [NMASK-1:0] cur_m;
  logic [NMASK-1:0] sel_m;
  logic [NMASK-1:0] nxt_m;
  logic [NMASK-1:0] set_ok;

  assign cur_m  = {cur.a, cur.i, cur.f};
  assign sel_m  = {imm[IMM_A_SEL], imm[IMM_I_SEL], imm[IMM_F_SEL]};
  assign set_ok = {1'b1, 1'b1, ~nmfi_lock};

  genvar g;
  generate
    for (g = 0; g < NMASK; g++) begin : g_mask
      always_comb begin
        nxt_m[g] = cur_m[g];
        if (sel_m[g]) begin
          if (imm[IMM_EN]) nxt_m[g] = 1'b0;
          else if (set_ok[g]) nxt_m[g] = 1'b1;
        end
      end
    end
  endgenerate

  always_comb begin
    nxt = cur;
    if (cur.mode != MODE_USER) begin
      nxt.f = nxt_m[0];
      nxt.i = nxt_m[1];
      nxt.a = nxt_m[2];
      if (imm[IMM_MODE]) nxt.mode = imm[MODE_W-1:0];
    end
  end
endmodule

// File: rtl/psr_state_reg.sv
module psr_state_reg
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  psr_cmd_e          sel,
  input  logic [IMM_W-1:0]  imm,
  input  psr_fields_t       chg_next,
  input  logic              flag_we,
  input  logic [FLAG_W-1:0] flag_in,
  output psr_fields_t       st,
  output logic [FLAG_W-1:0] flags
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= PSR_RESET;
    end else if (take) begin
      case (sel)
        CMD_CHG: st   <= chg_next;
        CMD_END: st.e <= imm[0];
        default: st   <= st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else if (flag_we) flags <= flag_in;
  end
endmodule

// File: rtl/psr_rd_port.sv
module psr_rd_port
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_rd,
  input  psr_fields_t       st,
  input  logic [FLAG_W-1:0] flags,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              cmd_ready
);
  logic [WORD_W-1:0] raw;

  always_comb begin
    raw = '0;
    raw[WORD_W-1:W_FLAG_LO] = flags;
    raw[W_E] = st.e;
    raw[W_A] = st.a;
    raw[W_I] = st.i;
    raw[W_F] = st.f;
    raw[MODE_W-1:0] = st.mode;
  end

  assign cmd_ready = ~rd_valid | rd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (take_rd) begin
      rd_valid <= 1'b1;
      rd_data  <= raw & RD_MASK;
    end else if (rd_ready) begin
      rd_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/psr_ctrl.sv
module psr_ctrl
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_sel,
  input  logic [IMM_W-1:0]  cmd_imm,
  input  logic              nmfi_lock,
  input  logic              flag_we,
  input  logic [FLAG_W-1:0] flag_in,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [WORD_W-1:0] rd_data,
  output logic [MODE_W-1:0] mode_o,
  output logic              f_o,
  output logic              i_o,
  output logic              a_o,
  output logic              e_o
);
  psr_fields_t       st;
  psr_fields_t       chg_next;
  logic [FLAG_W-1:0] flags;
  logic              take;
  psr_cmd_e          sel;

  assign sel  = psr_cmd_e'(cmd_sel);
  assign take = cmd_valid & cmd_ready;

  psr_chg_unit u_chg (
    .cur(st), .imm(cmd_imm), .nmfi_lock(nmfi_lock), .nxt(chg_next)
  );

  psr_state_reg u_reg (
    .clk(clk), .rst_n(rst_n), .take(take), .sel(sel), .imm(cmd_imm),
    .chg_next(chg_next), .flag_we(flag_we), .flag_in(flag_in),
    .st(st), .flags(flags)
  );

  psr_rd_port u_rd (
    .clk(clk), .rst_n(rst_n), .take_rd(take && (sel == CMD_READ)),
    .st(st), .flags(flags), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .cmd_ready(cmd_ready)
  );

  assign mode_o = st.mode;
  assign f_o    = st.f;
  assign i_o    = st.i;
  assign a_o    = st.a;
  assign e_o    = st.e;
endmodule

// File: rtl/psr_ctrl_chk.sv
module psr_ctrl_chk
  import psr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_sel,
  input logic [IMM_W-1:0]  cmd_imm,
  input logic              nmfi_lock,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [WORD_W-1:0] rd_data,
  input logic [MODE_W-1:0] mode_o,
  input logic              f_o,
  input logic              i_o,
  input logic              a_o,
  input logic              e_o
);
  logic take;
  assign take = cmd_valid & cmd_ready;

  // R5: no change-state effect in user mode
  a_r5_user_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_sel == 2'b00 && mode_o == MODE_USER)
      |=> (mode_o == MODE_USER && $stable(f_o) && $stable(i_o) && $stable(a_o)));

  // R3: F cannot rise while the lock is on
  a_r3_nmfi_blocks_f: assert property (@(posedge clk) disable iff (!rst_n)
    (nmfi_lock && !f_o) |=> !f_o);

  // R6: endianness command copies bit 0
  a_r6_endian: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_sel == 2'b01) |=> (e_o == $past(cmd_imm[0])));

  // R8: stalled readback word is held
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R8: no command taken during a stall
  a_r8_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |-> !cmd_ready);

  // R7: masked-out bits read as zero
  a_r7_mask: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ((rd_data & ~RD_MASK) == '0));

  // R10: unused select touches nothing
  a_r10_none: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_sel == 2'b11) |=> ($stable(mode_o) && $stable(f_o) && $stable(i_o)
                                    && $stable(a_o) && $stable(e_o)));
endmodule

bind psr_ctrl psr_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_sel(cmd_sel), .cmd_imm(cmd_imm), .nmfi_lock(nmfi_lock),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .mode_o(mode_o), .f_o(f_o), .i_o(i_o), .a_o(a_o), .e_o(e_o)
);

// File: tb/tb_psr_ctrl.sv
module tb_psr_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_sel = 2'b11;
  logic [9:0]  cmd_imm = '0;
  logic        nmfi_lock = 1'b0;
  logic        flag_we = 1'b0;
  logic [4:0]  flag_in = '0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [31:0] rd_data;
  logic [4:0]  mode_o;
  logic        f_o, i_o, a_o, e_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  psr_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_sel(cmd_sel), .cmd_imm(cmd_imm), .nmfi_lock(nmfi_lock),
    .flag_we(flag_we), .flag_in(flag_in), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .mode_o(mode_o),
    .f_o(f_o), .i_o(i_o), .a_o(a_o), .e_o(e_o)
  );

  // {sel, imm, nmfi, expected word after the command}
  typedef struct packed {
    logic [1:0]  sel;
    logic [9:0]  imm;
    logic        lock;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'b00, 10'h240, 1'b0, 32'h153}, // R2 clear I
    '{2'b00, 10'h040, 1'b1, 32'h1D3}, // R3 set I with lock
    '{2'b00, 10'h2A0, 1'b1, 32'h093}, // R2 clear F and A, lock on
    '{2'b00, 10'h020, 1'b1, 32'h093}, // R3 set F blocked
    '{2'b00, 10'h020, 1'b0, 32'h0D3}, // R3 set F allowed
    '{2'b00, 10'h11F, 1'b0, 32'h0DF}, // R4 mode to 11111
    '{2'b01, 10'h001, 1'b0, 32'h2DF}, // R6 E set
    '{2'b11, 10'h3FF, 1'b0, 32'h2DF}, // R10 no effect
    '{2'b00, 10'h110, 1'b0, 32'h2D0}, // R4 mode to user
    '{2'b00, 10'h3F3, 1'b0, 32'h2D0}, // R5 ignored in user
    '{2'b01, 10'h000, 1'b0, 32'h0D0}, // R6 E clear in user
    '{2'b00, 10'h080, 1'b0, 32'h0D0}  // R5 set A ignored in user
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] s, input logic [9:0] imm, input logic lock);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_sel = s; cmd_imm = imm; nmfi_lock = lock;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_sel = 2'b11;
  endtask

  task automatic read_word(output logic [31:0] w);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_sel = 2'b10;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_sel = 2'b11;
    check("R7 rd_valid", {31'b0, rd_valid}, 32'h1);
    w = rd_data;
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 fields", {22'b0, e_o, a_o, i_o, f_o, 1'b0, mode_o}, 32'h1D3);
    check("R1 rd_valid", {31'b0, rd_valid}, 32'h0);
    read_word(w);
    check("R1 readback", w, 32'h1D3);

    for (int k = 0; k < NV; k++) begin
      send(VEC[k].sel, VEC[k].imm, VEC[k].lock);
      check($sformatf("R2-table row %0d fields", k),
            {22'b0, e_o, a_o, i_o, f_o, 1'b0, mode_o}, VEC[k].exp);
      read_word(w);
      check($sformatf("R7 table row %0d word", k), w, VEC[k].exp);
    end

    // R9 flag update together with readback: old flags returned
    @(negedge clk);
    flag_we = 1'b1; flag_in = 5'b10101;
    cmd_valid = 1'b1; cmd_sel = 2'b10;
    @(negedge clk);
    flag_we = 1'b0; cmd_valid = 1'b0; cmd_sel = 2'b11;
    check("R9 same-cycle old flags", rd_data, 32'h0D0);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
    read_word(w);
    check("R9 new flags R7 layout", w, 32'hA80000D0);

    // R8 stall: hold word, refuse command
    @(negedge clk);
    cmd_valid = 1'b1; cmd_sel = 2'b10;
    @(negedge clk);
    cmd_sel = 2'b01; cmd_imm = 10'h001;   // offered during stall
    check("R8 cmd_ready low", {31'b0, cmd_ready}, 32'h0);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_sel = 2'b11;
    check("R8 word held", rd_data, 32'hA80000D0);
    check("R8 rd_valid held", {31'b0, rd_valid}, 32'h1);
    check("R8 refused cmd E", {31'b0, e_o}, 32'h0);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
    check("R8 drained", {31'b0, rd_valid}, 32'h0);

    // R1 reset again clears flags and restores mode
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    read_word(w);
    check("R1 re-reset word", w, 32'h1D3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule